// File: doc/BRIEF.md
# Two-Group Interrupt Vector Encoder

This block merges many single-cycle peripheral event pulses into two shared processor interrupt lines. One group serves the bus-protocol events (27 sources by default) and the other serves the data-path and interface events (14 sources by default). Each event sets a sticky pending bit. A pending bit whose enable bit is set raises its group's interrupt line.

For each group, a priority encoder picks the lowest-numbered source that is both pending and enabled and forms a vector from it. The vector helps the processor's fixed handler entry. Each group's entry holds a three-byte long jump, and the third byte is the low byte of the jump target. When the group's autovector bit is set, the unit replaces that byte on the processor's fetch path with the current vector. The shared handler therefore lands directly in a table of four-byte jump slots, one slot per source. When the autovector bit is clear, fetched bytes pass through unchanged.

Software uses a small register port. Writes are synchronous and reads are combinational. The port gives access to the pending, enable, vector and control registers of both groups.

Top module: `autovec_unit`

## Requirements
- R1: A one-cycle pulse on bit i of an event input sets pending bit i of that group at the next rising clock edge. The bit then stays set.
- R2: Writing to a pending register (address 0 for the bus group, 3 for the interface group) clears exactly the bits written as 1. Bits written as 0 keep their state. Pending bits change only through events or such writes.
- R3: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit is set after that edge.
- R4: A group's interrupt output is high exactly when some source is both pending and enabled. The enable register is at address 1 (bus group) or 4 (interface group), bit i enabling source i. A pending but disabled source does not raise the line.
- R5: A group's vector, readable at address 2 (bus) or 5 (interface), equals 4 × the lowest index that is pending and enabled. Index 0 has the highest priority. The vector is 0 when no source qualifies.
- R6: With control bit 0 (address 6) set, a fetch from address USB_ENTRY+2 (0x0045) returns the bus-group vector. With control bit 1 set, a fetch from FIF_ENTRY+2 (0x0055) returns the interface-group vector. Every other fetch address returns the memory byte.
- R7: With a group's control bit clear, a fetch from that group's substitution address returns the memory byte unchanged.
- R8: The two groups are independent. Events, enables and clears in one group never change the other group's pending bits, interrupt line or vector.
- R9: After reset, all pending, enable and control bits are 0, both interrupt lines are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_ev | input | N_USB | Bus-group event pulses |
| fif_ev | input | N_FIF | Interface-group event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| fetch_addr | input | AW | Processor fetch address |
| mem_byte | input | 8 | Byte returned by program memory |
| fetch_byte | output | 8 | Byte delivered to the processor |
| usb_irq | output | 1 | Bus-group interrupt |
| fif_irq | output | 1 | Interface-group interrupt |

## Verification
Several properties are checked on every cycle:
- an event always leaves its pending bit set;
- pending bits stay put when there is neither an event nor a clear write;
- a raised interrupt line always names a vector whose source is pending and enabled, and a low line always gives vector 0;
- fetches pass through when both autovector bits are clear.

Other behaviour is shown only by the bench's scenarios. These include:
- the exact lowest-index choice among several winners;
- the set-over-clear collision;
- substitution at exactly one address per group;
- independence of the groups under mixed random traffic.

// File: rtl/autovec_unit.sv
module autovec_unit #(
  parameter int N_USB = 27,
  parameter int N_FIF = 14,
  parameter int DW = 32,
  parameter int AW = 16,
  parameter logic [15:0] USB_ENTRY = 16'h0043,
  parameter logic [15:0] FIF_ENTRY = 16'h0053
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_USB-1:0] usb_ev,
  input  logic [N_FIF-1:0] fif_ev,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [AW-1:0]    fetch_addr,
  input  logic [7:0]       mem_byte,
  output logic [7:0]       fetch_byte,
  output logic             usb_irq,
  output logic             fif_irq
);
  localparam logic [2:0] A_UREQ = 3'd0, A_UEN = 3'd1, A_UVEC = 3'd2;
  localparam logic [2:0] A_FREQ = 3'd3, A_FEN = 3'd4, A_FVEC = 3'd5, A_CTL = 3'd6;
  localparam logic [AW-1:0] USB_SLOT = AW'(USB_ENTRY + 16'd2);
  localparam logic [AW-1:0] FIF_SLOT = AW'(FIF_ENTRY + 16'd2);

  logic [N_USB-1:0] usb_pend, usb_en, usb_act, usb_clr;
  logic [N_FIF-1:0] fif_pend, fif_en, fif_act, fif_clr;
  logic [7:0] usb_vec, fif_vec;
  logic av_usb, av_fif;

  assign usb_clr = (reg_wr && reg_addr == A_UREQ) ? reg_wdata[N_USB-1:0] : '0;
  assign fif_clr = (reg_wr && reg_addr == A_FREQ) ? reg_wdata[N_FIF-1:0] : '0;
  assign usb_act = usb_pend & usb_en;
  assign fif_act = fif_pend & fif_en;
  assign usb_irq = |usb_act;
  assign fif_irq = |fif_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usb_pend <= '0;
      fif_pend <= '0;
      usb_en   <= '0;
      fif_en   <= '0;
      av_usb   <= 1'b0;
      av_fif   <= 1'b0;
    end else begin
      usb_pend <= (usb_pend & ~usb_clr) | usb_ev;
      fif_pend <= (fif_pend & ~fif_clr) | fif_ev;
      if (reg_wr && reg_addr == A_UEN) usb_en <= reg_wdata[N_USB-1:0];
      if (reg_wr && reg_addr == A_FEN) fif_en <= reg_wdata[N_FIF-1:0];
      if (reg_wr && reg_addr == A_CTL) begin
        av_usb <= reg_wdata[0];
        av_fif <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    usb_vec = '0;
    for (int i = N_USB - 1; i >= 0; i--)
      if (usb_act[i]) usb_vec = 8'(i * 4);
  end

  always_comb begin
    fif_vec = '0;
    for (int i = N_FIF - 1; i >= 0; i--)
      if (fif_act[i]) fif_vec = 8'(i * 4);
  end

  always_comb begin
    case (reg_addr)
      A_UREQ:  reg_rdata = DW'(usb_pend);
      A_UEN:   reg_rdata = DW'(usb_en);
      A_UVEC:  reg_rdata = DW'(usb_vec);
      A_FREQ:  reg_rdata = DW'(fif_pend);
      A_FEN:   reg_rdata = DW'(fif_en);
      A_FVEC:  reg_rdata = DW'(fif_vec);
      A_CTL:   reg_rdata = DW'({av_fif, av_usb});
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    if (av_usb && fetch_addr == USB_SLOT)      fetch_byte = usb_vec;
    else if (av_fif && fetch_addr == FIF_SLOT) fetch_byte = fif_vec;
    else                                       fetch_byte = mem_byte;
  end
endmodule

module autovec_unit_chk #(
  parameter int N_USB = 27,
  parameter int N_FIF = 14,
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_USB-1:0] usb_ev,
  input logic [N_FIF-1:0] fif_ev,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [N_USB-1:0] usb_pend,
  input logic [N_USB-1:0] usb_en,
  input logic [N_FIF-1:0] fif_pend,
  input logic [N_FIF-1:0] fif_en,
  input logic [7:0]       usb_vec,
  input logic [7:0]       fif_vec,
  input logic             usb_irq,
  input logic             fif_irq,
  input logic             av_usb,
  input logic             av_fif,
  input logic [7:0]       mem_byte,
  input logic [7:0]       fetch_byte
);
  // R1
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((usb_pend & $past(usb_ev)) == $past(usb_ev)) &&
             ((fif_pend & $past(fif_ev)) == $past(fif_ev)));

  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == 3'd0) && usb_ev == '0) |=> $stable(usb_pend));

  // R5
  usb_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_irq |-> |(((usb_pend & usb_en) >> usb_vec[7:2]) & N_USB'(1)));

  // R5
  usb_idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !usb_irq |-> usb_vec == 8'd0);

  // R8
  fif_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fif_irq |-> |(((fif_pend & fif_en) >> fif_vec[7:2]) & N_FIF'(1)));

  // R7
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!av_usb && !av_fif) |-> fetch_byte == mem_byte);
endmodule

bind autovec_unit autovec_unit_chk #(.N_USB(N_USB), .N_FIF(N_FIF), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .usb_ev(usb_ev), .fif_ev(fif_ev),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .usb_pend(usb_pend), .usb_en(usb_en), .fif_pend(fif_pend), .fif_en(fif_en),
  .usb_vec(usb_vec), .fif_vec(fif_vec), .usb_irq(usb_irq), .fif_irq(fif_irq),
  .av_usb(av_usb), .av_fif(av_fif), .mem_byte(mem_byte), .fetch_byte(fetch_byte));

// File: tb/autovec_unit_test.sv
`timescale 1ns/1ps
module autovec_unit_test;
  logic clk = 0, rst_n = 0;
  logic [26:0] usb_ev = '0;
  logic [13:0] fif_ev = '0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] fetch_addr = '0;
  logic [7:0] mem_byte = '0, fetch_byte;
  logic usb_irq, fif_irq;
  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] mu = 0, mf = 0, meu = 0, mef = 0;
  logic avu = 0, avf = 0;

  always #2.5 clk = ~clk;

  autovec_unit uut (.clk(clk), .rst_n(rst_n), .usb_ev(usb_ev), .fif_ev(fif_ev),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_addr(fetch_addr), .mem_byte(mem_byte), .fetch_byte(fetch_byte),
    .usb_irq(usb_irq), .fif_irq(fif_irq));

  function automatic logic [31:0] pvec(input logic [31:0] act);
    logic [31:0] r = 0;
    for (int i = 31; i >= 0; i--) if (act[i]) r = i * 4;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_wr = 0; #0.5; d = reg_rdata;
  endtask

  task automatic fetch(input logic [15:0] a, input logic [7:0] m, output logic [7:0] b);
    fetch_addr = a; mem_byte = m; #0.5; b = fetch_byte;
  endtask

  task automatic cyc(input logic [26:0] eu, input logic [13:0] ef,
                     input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    usb_ev = eu; fif_ev = ef; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk); #0.5;
    mu = ((mu & ~((w && a == 0) ? d : 32'h0)) | {5'b0, eu}) & 32'h07FF_FFFF;
    mf = ((mf & ~((w && a == 3) ? d : 32'h0)) | {18'b0, ef}) & 32'h0000_3FFF;
    if (w && a == 1) meu = d & 32'h07FF_FFFF;
    if (w && a == 4) mef = d & 32'h0000_3FFF;
    if (w && a == 6) begin avu = d[0]; avf = d[1]; end
    usb_ev = '0; fif_ev = '0; reg_wr = 0;
  endtask

  task automatic check_all;
    logic [31:0] d; logic [7:0] b, m;
    logic [31:0] vu, vf;
    vu = pvec(mu & meu); vf = pvec(mf & mef);
    rd(0, d); check("R1/R2 usb pending", d, mu);
    rd(3, d); check("R1/R2 fifo pending", d, mf);
    rd(1, d); check("R4 usb enable", d, meu);
    rd(4, d); check("R4 fifo enable", d, mef);
    rd(2, d); check("R5 usb vector", d, vu);
    rd(5, d); check("R8 fifo vector", d, vf);
    rd(6, d); check("R6 control", d, {30'b0, avf, avu});
    check("R4 usb_irq", {31'b0, usb_irq}, {31'b0, |(mu & meu)});
    check("R8 fif_irq", {31'b0, fif_irq}, {31'b0, |(mf & mef)});
    m = 8'($urandom);
    fetch(16'h0045, m, b); check("R6/R7 usb slot", {24'b0, b}, avu ? vu : {24'b0, m});
    fetch(16'h0055, m, b); check("R6/R7 fifo slot", {24'b0, b}, avf ? vf : {24'b0, m});
    fetch(16'h0044, m, b); check("R6 other addr", {24'b0, b}, {24'b0, m});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #0.5;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R9 reset read", d, 0);
    end
    check("R9 irq low", {30'b0, usb_irq, fif_irq}, 0);
    @(negedge clk); rst_n = 1;

    // R5: lowest-priority source alone, then priority pick
    cyc(0, 0, 1, 1, 32'h07FF_FFFF);
    cyc(27'h400_0000, 0, 0, 0, 0); check_all;
    rd(2, d); check("R5 index 26 vector", d, 104);
    cyc(27'h000_0008, 0, 0, 0, 0); check_all;
    rd(2, d); check("R5 index 3 wins", d, 12);
    // R4: disabled source does not raise the line
    cyc(0, 0, 1, 1, 0); check_all;
    check("R4 masked irq", {31'b0, usb_irq}, 0);
    rd(2, d); check("R5 none qualifies", d, 0);
    // R3: set and clear in the same cycle
    cyc(27'h20, 0, 1, 0, 32'h0400_0020); check_all;
    rd(0, d); check("R3 set wins", d & 32'h0400_0020, 32'h20);
    // R2: writing zero clears nothing
    cyc(0, 0, 1, 0, 0); check_all;
    // R7 then R6 on substitution
    cyc(0, 0, 1, 1, 32'h28); check_all;
    cyc(0, 0, 1, 6, 1); check_all;
    // R8: fifo traffic leaves usb untouched
    cyc(0, 14'h2001, 1, 4, 32'h2000); check_all;
    cyc(0, 0, 1, 6, 3); check_all;
    cyc(0, 0, 1, 3, 32'h3FFF); check_all;

    for (int n = 0; n < 400; n++) begin
      logic [26:0] eu; logic [13:0] ef; logic [2:0] a; bit w;
      eu = ($urandom % 3 == 0) ? (27'd1 << ($urandom % 27)) : '0;
      ef = ($urandom % 3 == 0) ? (14'd1 << ($urandom % 14)) : '0;
      w = ($urandom % 2) == 1;
      a = 3'($urandom % 7);
      cyc(eu, ef, w, a, $urandom);
      check_all;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule